// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from up to 31 numbered sources (numbers 1 to 31) and drives a single active-low interrupt line towards a processor. Every source owns a 3-bit priority, a capture mode (level or rising edge), an enable bit and a vector word. Software reaches all of this through a plain register bus with select, write strobe, address and data.

Arbitration happens at the moment software reads the vector register, not when the line first went low. That read returns the vector of the winning source and starts its service. The winner's number and priority are pushed onto an internal stack of in-service levels. While anything is in service, the interrupt line reasserts only for a source that outranks the level on top of the stack. An end-of-service write pops the stack, and any requests that were held back then compete again. When no source qualifies, a read returns a programmable fallback vector and leaves the stack alone.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, irq_n is 1. The enable mask (read at 0x4C), the pending mask (read at 0x54) and the in-service word (read at 0x44) all read 0. A vector read at 0x40 returns the fallback vector, whose reset value is 0.
- R2: A level source (mode bit 4 = 0) is pending while its synchronized input is high. From an input rising just after a clock edge, irq_n goes low on the third rising edge and not earlier.
- R3: An edge source (mode bit 4 = 1) latches pending on a rising input and stays pending after the input falls. irq_n goes low on the fourth rising edge after the input rises, and not earlier.
- R4: A vector read (0x40) returns the vector (written at 0x20 + n) of the enabled, pending, qualifying source with the highest priority (mode bits 2:0, where 7 is the highest). Among equal priorities, the lowest source number wins.
- R5: The winner is chosen at the read. A higher-priority source that became pending after irq_n fell wins over the earlier request.
- R6: A vector read that selects a source pushes it. The in-service word at 0x44 then shows source number in bits 4:0 and priority in bits 10:8. The read also clears that source's pending bit if it is edge-captured.
- R7: While the stack is not empty, only a source whose priority is strictly greater than the top-of-stack priority can drive irq_n low or be selected. Sources at equal or lower priority wait.
- R8: A write to 0x48 pops the stack and restores the previous in-service word. Requests that were held back then assert irq_n again.
- R9: A write to 0x48 while the stack is empty has no effect: the in-service word stays 0 and irq_n is unchanged.
- R10: A vector read with no qualifying source returns the fallback vector (read/write at 0x58) and leaves the in-service word unchanged.
- R11: A disabled source never drives irq_n low and is never selected. Writing a mask to 0x4C sets enable bits, and writing a mask to 0x50 clears them.
- R12: Source 0 is reserved. Its mode register reads 0, its enable bit reads 0, its pending bit reads 0, and its input never affects irq_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | NUM_SRC | Raw request inputs, bit n is source n |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | VEC_W | Write data |
| bus_rdata | output | VEC_W | Read data, valid during the access cycle |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The bench counts edges from an input change to the fall of irq_n for both capture modes. A design with one synchronizer flop too many or too few would miss that exact cycle. It raises a higher-priority source after the line is already low, so a design that latched the winner early would return the wrong vector. It also pairs two equal-priority sources, where an inverted tie rule shows up as the higher-numbered vector. Nested reads with equal, lower and higher newcomers, an end-of-service write on an empty stack, disabled sources and the reserved source 0 are covered too. In those cases a design that compared with >= instead of >, popped below zero, or let source 0 through would show a wrong line level, a wrong in-service word or a wrong vector. Random toggling, enable changes, reprioritisation and service reads then run against a reference model of the stack and pending state.

// File: rtl/nic_pkg.sv
package nic_pkg;

  // control register offsets (outside the per-source windows)
  localparam int OFS_VEC_RD  = 'h40;
  localparam int OFS_CUR     = 'h44;
  localparam int OFS_EOI     = 'h48;
  localparam int OFS_EN_SET  = 'h4C;
  localparam int OFS_EN_CLR  = 'h50;
  localparam int OFS_PEND    = 'h54;
  localparam int OFS_SPUR    = 'h58;

  // field positions
  localparam int MODE_EDGE_BIT = 4;
  localparam int CUR_PRIO_LSB  = 8;

  typedef enum logic [3:0] {
    CMD_IDLE,
    CMD_MODE_WR,
    CMD_VEC_WR,
    CMD_VEC_RD,
    CMD_EOI,
    CMD_EN_SET,
    CMD_EN_CLR,
    CMD_SPUR_WR
  } bus_cmd_e;

endpackage

// File: rtl/nic_src_capture.sv
module nic_src_capture #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] edge_mode,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cap
    logic meta_q, sync_q, prev_q, ep_q;
    logic ep_d, rise;

    assign rise = sync_q & ~prev_q;

    always_comb begin
      if (edge_mode[s]) ep_d = (ep_q & ~clr[s]) | rise;
      else              ep_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
        ep_q   <= 1'b0;
      end else begin
        meta_q <= src_in[s];
        sync_q <= meta_q;
        prev_q <= sync_q;
        ep_q   <= ep_d;
      end
    end

    assign pend[s] = edge_mode[s] ? ep_q : sync_q;

    // R3: a rising edge in edge mode always latches
    a_r3_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[s] && rise) |=> ep_q);

    // R6: selection clears the latch unless a new edge arrives
    a_r6_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[s] && clr[s] && !rise) |=> !ep_q);
  end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0]             en,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all,
  input  logic                           nested,
  input  logic [PRIO_W-1:0]              cur_prio,
  output logic                           found,
  output logic [SRC_W-1:0]               win_src,
  output logic [PRIO_W-1:0]              win_prio
);

  // strict '>' on the running best keeps the lowest number on ties
  always_comb begin
    found    = 1'b0;
    win_src  = '0;
    win_prio = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (s != 0 && pend[s] && en[s]
          && (!nested || prio_all[s] > cur_prio)
          && (!found || prio_all[s] > win_prio)) begin
        found    = 1'b1;
        win_src  = SRC_W'(s);
        win_prio = prio_all[s];
      end
    end
  end

  // R12: the reserved slot never wins
  a_r12_no_src0: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (win_src != '0));

  // R11: a winner is always an enabled pending source
  a_r11_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend[win_src] && en[win_src]));

endmodule

// File: rtl/nic_prio_stack.sv
module nic_prio_stack #(
  parameter int DEPTH  = 8,
  parameter int SRC_W  = 5,
  parameter int PRIO_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [SRC_W-1:0]  push_src,
  input  logic [PRIO_W-1:0] push_prio,
  output logic              empty,
  output logic              full,
  output logic [SRC_W-1:0]  top_src,
  output logic [PRIO_W-1:0] top_prio,
  output logic [CNT_W-1:0]  level
);

  logic [SRC_W-1:0]  src_mem  [DEPTH];
  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, top_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign wr_en   = push && !full;
  assign wr_idx  = IDX_W'(cnt_q);
  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign level   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)            cnt_d = cnt_q + 1'b1;
    else if (pop && !empty) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_mem[wr_idx]  <= push_src;
      prio_mem[wr_idx] <= push_prio;
    end
  end

  assign top_src  = empty ? '0 : src_mem[top_idx];
  assign top_prio = empty ? '0 : prio_mem[top_idx];

  // R7: strict nesting means a push never meets a full stack
  a_r7_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9: popping an empty stack leaves it empty
  a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

  // R8: a pop on a non-empty stack drops exactly one level
  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (level == CNT_W'($past(level) - 1'b1)));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 32,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [VEC_W-1:0]   bus_wdata,
  output logic [VEC_W-1:0]   bus_rdata,
  output logic               irq_n
);

  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int WIN_W = ADDR_W - SRC_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // ---------------- reset release ----------------
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  // ---------------- bus decode ----------------
  bus_cmd_e         cmd;
  logic [WIN_W-1:0] win;
  logic [SRC_W-1:0] idx;

  assign win = bus_addr[ADDR_W-1:SRC_W];
  assign idx = bus_addr[SRC_W-1:0];

  always_comb begin
    cmd = CMD_IDLE;
    if (bus_sel) begin
      if (bus_wr) begin
        if (win == '0)                            cmd = CMD_MODE_WR;
        else if (win == WIN_W'(1))                cmd = CMD_VEC_WR;
        else if (bus_addr == ADDR_W'(OFS_EOI))    cmd = CMD_EOI;
        else if (bus_addr == ADDR_W'(OFS_EN_SET)) cmd = CMD_EN_SET;
        else if (bus_addr == ADDR_W'(OFS_EN_CLR)) cmd = CMD_EN_CLR;
        else if (bus_addr == ADDR_W'(OFS_SPUR))   cmd = CMD_SPUR_WR;
      end else if (bus_addr == ADDR_W'(OFS_VEC_RD)) begin
        cmd = CMD_VEC_RD;
      end
    end
  end

  // ---------------- per-source configuration ----------------
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all;
  logic [NUM_SRC-1:0]             edge_all;
  logic [NUM_SRC-1:0][VEC_W-1:0]  vec_all;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cfg
    if (s == 0) begin : g_rsvd
      assign prio_all[s] = '0;
      assign edge_all[s] = 1'b0;
      assign vec_all[s]  = '0;
    end else begin : g_live
      logic [PRIO_W-1:0] prio_q;
      logic              edge_q;
      logic [VEC_W-1:0]  vec_q;
      logic              hit;

      assign hit = (idx == SRC_W'(s));

      always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n) begin
          prio_q <= '0;
          edge_q <= 1'b0;
        end else if (cmd == CMD_MODE_WR && hit) begin
          prio_q <= bus_wdata[PRIO_W-1:0];
          edge_q <= bus_wdata[MODE_EDGE_BIT];
        end
      end

      always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n)                      vec_q <= '0;
        else if (cmd == CMD_VEC_WR && hit)    vec_q <= bus_wdata;
      end

      assign prio_all[s] = prio_q;
      assign edge_all[s] = edge_q;
      assign vec_all[s]  = vec_q;
    end
  end

  // ---------------- capture, arbitration, stack ----------------
  logic [NUM_SRC-1:0] pend, clr, en_q, en_d;
  logic               found, stk_empty, stk_full;
  logic [SRC_W-1:0]   win_src, top_src;
  logic [PRIO_W-1:0]  win_prio, top_prio;
  logic [CNT_W-1:0]   stk_level;
  logic               push, pop;

  assign push = (cmd == CMD_VEC_RD) && found;
  assign pop  = (cmd == CMD_EOI);

  always_comb begin
    clr = '0;
    if (push) clr[win_src] = 1'b1;
  end

  nic_src_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .src_in    (irq_src),
    .edge_mode (edge_all),
    .clr       (clr),
    .pend      (pend)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pend     (pend),
    .en       (en_q),
    .prio_all (prio_all),
    .nested   (!stk_empty),
    .cur_prio (top_prio),
    .found    (found),
    .win_src  (win_src),
    .win_prio (win_prio)
  );

  nic_prio_stack #(.DEPTH(DEPTH), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (push),
    .pop       (pop),
    .push_src  (win_src),
    .push_prio (win_prio),
    .empty     (stk_empty),
    .full      (stk_full),
    .top_src   (top_src),
    .top_prio  (top_prio),
    .level     (stk_level)
  );

  // ---------------- global registers ----------------
  logic [VEC_W-1:0] spur_q, spur_d;
  logic             irq_n_q, irq_n_d;

  always_comb begin
    en_d    = en_q;
    spur_d  = spur_q;
    irq_n_d = ~found;
    if (cmd == CMD_EN_SET) en_d = en_q | bus_wdata[NUM_SRC-1:0];
    if (cmd == CMD_EN_CLR) en_d = en_q & ~bus_wdata[NUM_SRC-1:0];
    if (cmd == CMD_SPUR_WR) spur_d = bus_wdata;
    en_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q    <= '0;
      spur_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      en_q    <= en_d;
      spur_q  <= spur_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n = irq_n_q;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (win == '0) begin
      bus_rdata[PRIO_W-1:0]    = prio_all[idx];
      bus_rdata[MODE_EDGE_BIT] = edge_all[idx];
    end else if (win == WIN_W'(1)) begin
      bus_rdata = vec_all[idx];
    end else if (bus_addr == ADDR_W'(OFS_VEC_RD)) begin
      bus_rdata = found ? vec_all[win_src] : spur_q;
    end else if (bus_addr == ADDR_W'(OFS_CUR)) begin
      bus_rdata[SRC_W-1:0]                = top_src;
      bus_rdata[CUR_PRIO_LSB +: PRIO_W]   = top_prio;
    end else if (bus_addr == ADDR_W'(OFS_EN_SET)) begin
      bus_rdata[NUM_SRC-1:0] = en_q;
    end else if (bus_addr == ADDR_W'(OFS_PEND)) begin
      bus_rdata[NUM_SRC-1:0] = pend & ~NUM_SRC'(1);
    end else if (bus_addr == ADDR_W'(OFS_SPUR)) begin
      bus_rdata = spur_q;
    end
  end

  // R7: a nested push must outrank the level in service
  a_r7_strict_nest: assert property (@(posedge clk) disable iff (!rst_core_n)
    (push && !stk_empty) |-> (win_prio > top_prio));

  // R10: a read with no qualifying source leaves the stack untouched
  a_r10_spur_no_push: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cmd == CMD_VEC_RD && !found) |=> $stable(stk_level));

  // R2: irq_n only falls when some source qualified the cycle before
  a_r2_irq_cause: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(irq_n) |-> $past(found));

endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_IVR  = 8'h40;
  localparam logic [7:0] A_CUR  = 8'h44;
  localparam logic [7:0] A_EOI  = 8'h48;
  localparam logic [7:0] A_ENS  = 8'h4C;
  localparam logic [7:0] A_ENC  = 8'h50;
  localparam logic [7:0] A_PEND = 8'h54;
  localparam logic [7:0] A_SPUR = 8'h58;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_src;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  int nchk = 0;
  int nfail = 0;

  // ---------------- reference model ----------------
  bit [31:0]   m_en, m_in, m_ep;
  int          m_prio [32];
  bit          m_edge [32];
  logic [31:0] m_vec  [32];
  logic [31:0] m_spur;
  int          sk_src [8];
  int          sk_pr  [8];
  int          sk_n;

  function automatic bit m_pend_of(int s);
    if (s == 0) return 1'b0;
    return m_edge[s] ? m_ep[s] : m_in[s];
  endfunction

  function automatic logic [31:0] m_pendvec();
    logic [31:0] v = '0;
    for (int s = 1; s < 32; s++) v[s] = m_pend_of(s);
    return v;
  endfunction

  function automatic int m_winner();
    int best = -1;
    int bp = -1;
    for (int s = 1; s < 32; s++) begin
      if (m_pend_of(s) && m_en[s] && (sk_n == 0 || m_prio[s] > sk_pr[sk_n-1])
          && m_prio[s] > bp) begin
        best = s;
        bp = m_prio[s];
      end
    end
    return best;
  endfunction

  function automatic logic [31:0] m_cur();
    if (sk_n == 0) return 32'h0;
    return 32'((sk_pr[sk_n-1] << 8) | sk_src[sk_n-1]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic set_mode(input int s, input int p, input bit e);
    wr(8'(s), 32'((int'(e) << 4) | p));
    if (s != 0) begin
      m_prio[s] = p;
      m_edge[s] = e;
      if (!e) m_ep[s] = 1'b0;
    end
  endtask

  task automatic en_set(input logic [31:0] m);
    wr(A_ENS, m);
    m_en = (m_en | m) & ~32'h1;
  endtask

  task automatic en_clr(input logic [31:0] m);
    wr(A_ENC, m);
    m_en = m_en & ~m;
  endtask

  // drive at a falling edge, model the capture result
  task automatic drive_src(input int s, input bit v);
    @(negedge clk);
    if (s != 0 && m_edge[s] && v && !m_in[s]) m_ep[s] = 1'b1;
    irq_src[s] = v;
    m_in[s] = v;
  endtask

  task automatic do_ivr(input string req, output logic [31:0] got);
    int w;
    logic [31:0] exp;
    w = m_winner();
    exp = (w < 0) ? m_spur : m_vec[w];
    rd(A_IVR, got);
    chk(req, got, exp);
    if (w >= 0) begin
      sk_src[sk_n] = w;
      sk_pr[sk_n] = m_prio[w];
      sk_n++;
      if (m_edge[w]) m_ep[w] = 1'b0;
    end
  endtask

  task automatic do_eoi();
    wr(A_EOI, 32'h0);
    if (sk_n > 0) sk_n--;
  endtask

  task automatic check_state(input string req);
    logic [31:0] v;
    settle();
    chk(req, 32'(irq_n), 32'(m_winner() < 0));
    rd(A_PEND, v);
    chk(req, v, m_pendvec());
    rd(A_CUR, v);
    chk(req, v, m_cur());
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    int          seed_dummy;
    rst_n = 1'b0; irq_src = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_en = '0; m_in = '0; m_ep = '0; m_spur = '0; sk_n = 0;
    for (int s = 0; s < 32; s++) begin
      m_prio[s] = 0; m_edge[s] = 1'b0; m_vec[s] = '0;
    end
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk("R1", 32'(irq_n), 32'h1);
    rd(A_ENS, v);  chk("R1", v, 32'h0);
    rd(A_PEND, v); chk("R1", v, 32'h0);
    rd(A_CUR, v);  chk("R1", v, 32'h0);
    rd(A_IVR, v);  chk("R1", v, 32'h0);

    // program fallback and vectors
    wr(A_SPUR, 32'hDEAD_0000); m_spur = 32'hDEAD_0000;
    rd(A_SPUR, v); chk("R10", v, 32'hDEAD_0000);
    for (int s = 1; s < 32; s++) begin
      m_vec[s] = {16'hC0DE, 8'(s), 8'($urandom)};
      wr(8'(32 + s), m_vec[s]);
    end

    // R2: level latency, exactly three rising edges
    set_mode(5, 3, 1'b0);
    en_set(32'h1 << 5);
    drive_src(5, 1'b1);
    repeat (2) @(negedge clk);
    chk("R2", 32'(irq_n), 32'h1);
    @(negedge clk);
    chk("R2", 32'(irq_n), 32'h0);
    do_ivr("R4", v);
    chk("R4", v, m_vec[5]);
    rd(A_CUR, v); chk("R6", v, 32'h0000_0305);
    settle();
    chk("R7", 32'(irq_n), 32'h1);
    drive_src(5, 1'b0);
    do_eoi();
    check_state("R8");

    // R3: edge latency and latch, exactly four rising edges
    set_mode(9, 2, 1'b1);
    en_set(32'h1 << 9);
    drive_src(9, 1'b1);
    repeat (3) @(negedge clk);
    chk("R3", 32'(irq_n), 32'h1);
    @(negedge clk);
    chk("R3", 32'(irq_n), 32'h0);
    drive_src(9, 1'b0);
    settle();
    rd(A_PEND, v); chk("R3", v & (32'h1 << 9), 32'h1 << 9);
    do_ivr("R6", v);
    chk("R6", v, m_vec[9]);
    rd(A_PEND, v); chk("R6", v & (32'h1 << 9), 32'h0);
    do_eoi();
    check_state("R6");

    // R5, R4, R7, R8, R10: decision at read time and nesting
    set_mode(10, 4, 1'b0);
    set_mode(12, 4, 1'b0);
    set_mode(11, 6, 1'b0);
    set_mode(13, 5, 1'b0);
    en_set(32'h0000_3C00);
    drive_src(12, 1'b1);
    drive_src(10, 1'b1);
    settle();
    chk("R5", 32'(irq_n), 32'h0);
    drive_src(11, 1'b1);
    settle();
    do_ivr("R5", v);
    chk("R5", v, m_vec[11]);
    do_ivr("R10", v);
    chk("R10", v, 32'hDEAD_0000);
    rd(A_CUR, v); chk("R10", v, 32'h0000_060B);
    drive_src(11, 1'b0);
    do_eoi();
    do_ivr("R4", v);
    chk("R4", v, m_vec[10]);
    settle();
    chk("R7", 32'(irq_n), 32'h1);
    drive_src(13, 1'b1);
    settle();
    chk("R7", 32'(irq_n), 32'h0);
    do_ivr("R7", v);
    chk("R7", v, m_vec[13]);
    drive_src(13, 1'b0);
    do_eoi();
    rd(A_CUR, v); chk("R8", v, 32'h0000_040A);
    do_eoi();
    settle();
    chk("R8", 32'(irq_n), 32'h0);
    drive_src(10, 1'b0);
    drive_src(12, 1'b0);
    check_state("R8");

    // R9: end-of-service on empty stack
    do_eoi();
    settle();
    rd(A_CUR, v); chk("R9", v, 32'h0);
    chk("R9", 32'(irq_n), 32'h1);
    check_state("R9");

    // R11: enable gating
    set_mode(20, 7, 1'b0);
    drive_src(20, 1'b1);
    settle();
    chk("R11", 32'(irq_n), 32'h1);
    do_ivr("R11", v);
    chk("R11", v, 32'hDEAD_0000);
    en_set(32'h1 << 20);
    settle();
    chk("R11", 32'(irq_n), 32'h0);
    en_clr(32'h1 << 20);
    settle();
    chk("R11", 32'(irq_n), 32'h1);
    rd(A_ENS, v); chk("R11", v, m_en);
    drive_src(20, 1'b0);

    // R12: reserved source 0
    set_mode(0, 7, 1'b0);
    rd(8'h00, v); chk("R12", v, 32'h0);
    en_set(32'h1);
    rd(A_ENS, v); chk("R12", v & 32'h1, 32'h0);
    drive_src(0, 1'b1);
    settle();
    chk("R12", 32'(irq_n), 32'h1);
    rd(A_PEND, v); chk("R12", v & 32'h1, 32'h0);
    drive_src(0, 1'b0);

    // random phase: fresh modes with all inputs low
    for (int s = 1; s < 32; s++) set_mode(s, 0, 1'b0);
    for (int s = 1; s < 32; s++) set_mode(s, int'($urandom % 8), 1'($urandom % 2));
    check_state("R4");
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0, 1, 2, 3: begin
          int s;
          s = int'($urandom % 32);
          drive_src(s, !m_in[s]);
        end
        4, 5: do_ivr("R4", v);
        6: do_eoi();
        7: en_set($urandom & $urandom);
        8: en_clr($urandom & $urandom);
        default: begin
          int s;
          s = 1 + int'($urandom % 31);
          set_mode(s, int'($urandom % 8), m_edge[s]);
        end
      endcase
      check_state("R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule